// File: doc/BRIEF.md
# Non-Volatile Commit Sequencer

This block sits behind a serial configuration port. It decides whether a channel value that has just been shifted in gets written to the non-volatile shadow copy. The serial front end reports frame progress: a pulse when the start bit is taken and a pulse, carrying the channel index and data, when the last data bit arrives. A program request line from the host qualifies the commit. The request must rise after the start bit and must already be high on the clock edge that follows the end of the frame. It must then stay high for a minimum number of clock cycles before the shadow storage is written.

If the request is missing or arrived too early, the pending value is dropped and a one-cycle discard pulse is issued two clock edges after the frame ends. A request that falls before the minimum has elapsed aborts the commit silently. Chip select low abandons any frame or commit still in progress. The write to shadow storage leaves on a valid/ready channel. `wr_valid` stays high, with channel and data held constant, until the storage accepts the write with `wr_ready`. The storage may stall for as long as it needs, and `busy` stays high for the whole stall.

Top module: `nvc_commit_seq`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `discard` are low.
- R2: With `cs` high, a frame whose `prog_req` is low on the edge that samples `start_seen` and high on the edge after the one that samples `frame_done` is accepted, and `busy` is high after that edge.
- R3: A `prog_req` that is already high on the edge that samples `start_seen` does not qualify the frame, even if it is high on the edge after the frame ends; the frame is discarded.
- R4: When a frame is not accepted, `discard` is high for exactly one cycle, following the second edge after the one that samples `frame_done`, and no write is issued.
- R5: `wr_valid` rises after `MIN_PROG_CYCLES`+1 consecutive edges sampling `prog_req` high, counted from the acceptance edge, and carries the channel index and data latched from the frame.
- R6: If `prog_req` is sampled low before the minimum is reached, `busy` falls after that edge, and neither a write nor a discard follows.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_chan` and `wr_data` hold. The edge that samples both high completes the write, and after it `busy` and `wr_valid` are low.
- R8: `start_seen` and `frame_done` pulses are ignored while `busy` is high; the value written is the one latched at acceptance.
- R9: `cs` sampled low before the write is raised returns the block to idle: `busy` falls, and no discard or write follows.
- R10: A value is committed even if it equals the value committed before; each accepted commit produces its own write.
- R11: A `frame_done` pulse with no start bit taken before it is ignored: no busy, no discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, kept running through programming |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; low abandons frames and pending commits |
| prog_req | input | 1 | Program request from the host |
| start_seen | input | 1 | One-cycle pulse: start bit taken |
| frame_done | input | 1 | One-cycle pulse: last data bit taken |
| frame_chan | input | CHAN_W | Channel index of the finished frame |
| frame_data | input | DATA_W | Data of the finished frame |
| busy | output | 1 | Commit accepted and not yet completed |
| discard | output | 1 | One-cycle pulse: pending value dropped |
| wr_valid | output | 1 | Shadow write request |
| wr_ready | input | 1 | Shadow storage accepts the write |
| wr_chan | output | CHAN_W | Channel index of the write |
| wr_data | output | DATA_W | Data of the write |

## Verification
Two functions can fall on the same edge. One is the qualification check on the request, made on the edge after the frame ends. The other is the arrival of new frame-progress pulses, which the busy state must shut out. The bench drives a second start and end-of-frame pulse, with different data, while a commit is counting. The shadow write must still carry the first value. The other collision is chip select falling on the qualification edge while the request is high. That is judged by `busy`, `discard` and the write count all staying quiet afterwards.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_HELD,
    ST_DROP,
    ST_PROG,
    ST_WRITE
  } nvc_state_e;
endpackage

// File: rtl/nvc_window.sv
// Remembers whether the program request was low when the start bit was taken.
module nvc_window (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic prog_req,
  output logic req_clean
);
  always_ff @(posedge clk) begin
    if (!rst_n)    req_clean <= 1'b0;
    else if (take) req_clean <= ~prog_req;
  end
endmodule

// File: rtl/nvc_frame_hold.sv
// Latches the channel index and data of a completed frame.
module nvc_frame_hold #(
  parameter int CHAN_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [DATA_W-1:0] in_data,
  output logic [CHAN_W-1:0] out_chan,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_chan <= '0;
      out_data <= '0;
    end else if (load) begin
      out_chan <= in_chan;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/nvc_hold_timer.sv
// Counts program-request cycles; done fires on the cycle that reaches the minimum.
module nvc_hold_timer #(
  parameter int MIN_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (MIN_CYCLES > 1) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/nvc_commit_seq.sv
module nvc_commit_seq #(
  parameter int CHAN_W          = 2,
  parameter int DATA_W          = 8,
  parameter int MIN_PROG_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              prog_req,
  input  logic              start_seen,
  input  logic              frame_done,
  input  logic [CHAN_W-1:0] frame_chan,
  input  logic [DATA_W-1:0] frame_data,
  output logic              busy,
  output logic              discard,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CHAN_W-1:0] wr_chan,
  output logic [DATA_W-1:0] wr_data
);
  import nvc_pkg::*;

  nvc_state_e state, state_n;
  logic       discard_n;
  logic       req_clean;
  logic       tim_done;
  logic       start_take;
  logic       frame_load;

  assign start_take = (state == ST_IDLE) && cs && start_seen;
  assign frame_load = (state == ST_ARMED) && cs && frame_done;

  nvc_window u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (start_take),
    .prog_req  (prog_req),
    .req_clean (req_clean)
  );

  nvc_frame_hold #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_load),
    .in_chan  (frame_chan),
    .in_data  (frame_data),
    .out_chan (wr_chan),
    .out_data (wr_data)
  );

  nvc_hold_timer #(.MIN_CYCLES(MIN_PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_PROG),
    .run   ((state == ST_PROG) && prog_req && cs),
    .done  (tim_done)
  );

  always_comb begin
    state_n   = state;
    discard_n = 1'b0;
    unique case (state)
      ST_IDLE:  if (start_take) state_n = ST_ARMED;
      ST_ARMED: if (frame_done) state_n = ST_HELD;
      ST_HELD:  state_n = (prog_req && req_clean) ? ST_PROG : ST_DROP;
      ST_DROP: begin
        state_n   = ST_IDLE;
        discard_n = 1'b1;
      end
      ST_PROG: begin
        if (!prog_req)     state_n = ST_IDLE;
        else if (tim_done) state_n = ST_WRITE;
      end
      ST_WRITE: if (wr_ready) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
    if (!cs && state != ST_WRITE) begin
      state_n   = ST_IDLE;
      discard_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      discard <= 1'b0;
    end else begin
      state   <= state_n;
      discard <= discard_n;
    end
  end

  assign busy     = (state == ST_PROG) || (state == ST_WRITE);
  assign wr_valid = (state == ST_WRITE);
endmodule

// File: rtl/nvc_commit_seq_chk.sv
module nvc_commit_seq_chk #(
  parameter int CHAN_W          = 2,
  parameter int DATA_W          = 8,
  parameter int MIN_PROG_CYCLES = 300000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              prog_req,
  input logic              busy,
  input logic              discard,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [CHAN_W-1:0] wr_chan,
  input logic [DATA_W-1:0] wr_data
);
  localparam int RUN_W = $clog2(MIN_PROG_CYCLES + 2);
  localparam logic [RUN_W-1:0] SAT = RUN_W'(MIN_PROG_CYCLES + 1);

  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n || !prog_req) run <= '0;
    else if (run != SAT)     run <= run + 1'b1;
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !discard && !busy));

  assert_discard_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);

  assert_discard_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(discard && busy));

  assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (run == SAT));

  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_valid && !prog_req) |=> !busy);

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_chan) && $stable(wr_data)));

  assert_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  assert_cs_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !wr_valid) |=> !busy);
endmodule

bind nvc_commit_seq nvc_commit_seq_chk #(
  .CHAN_W(CHAN_W), .DATA_W(DATA_W), .MIN_PROG_CYCLES(MIN_PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .prog_req(prog_req), .busy(busy),
  .discard(discard), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_chan(wr_chan), .wr_data(wr_data)
);

// File: tb/nvc_commit_seq_tb.sv
`timescale 1ns/1ps
module nvc_commit_seq_tb;
  localparam int MINC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       prog_req = 1'b0;
  logic       start_seen = 1'b0;
  logic       frame_done = 1'b0;
  logic [1:0] frame_chan = '0;
  logic [7:0] frame_data = '0;
  logic       wr_ready = 1'b0;
  logic       busy, discard, wr_valid;
  logic [1:0] wr_chan;
  logic [7:0] wr_data;

  int n_run = 0;
  int n_fail = 0;
  int n_wr = 0;
  logic [1:0] last_chan = '0;
  logic [7:0] last_data = '0;

  always #5 clk = ~clk;

  nvc_commit_seq #(.CHAN_W(2), .DATA_W(8), .MIN_PROG_CYCLES(MINC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .prog_req(prog_req),
    .start_seen(start_seen), .frame_done(frame_done),
    .frame_chan(frame_chan), .frame_data(frame_data),
    .busy(busy), .discard(discard), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_data(wr_data)
  );

  always @(posedge clk) if (wr_valid && wr_ready) begin
    n_wr++;
    last_chan <= wr_chan;
    last_data <= wr_data;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Start bit, two idle cycles, end of frame, then the qualification edge.
  task automatic frame(input logic [1:0] ch, input logic [7:0] d,
                       input logic pre, input logic at_chk);
    start_seen = 1'b1; prog_req = pre; tick();
    start_seen = 1'b0; prog_req = 1'b0; tick(); tick();
    frame_chan = ch; frame_data = d; frame_done = 1'b1; tick();
    frame_done = 1'b0; prog_req = at_chk; tick();
  endtask

  task automatic commit(input logic [1:0] ch, input logic [7:0] d, input int stall,
                        input logic intrude);
    int wr0;
    wr0 = n_wr;
    frame(ch, d, 1'b0, 1'b1);
    check("R2 busy after acceptance", busy, 1);
    check("R5 no early write", wr_valid, 0);
    for (int i = 0; i < MINC - 1; i++) begin
      if (intrude && i == 0) begin
        start_seen = 1'b1; frame_done = 1'b1; frame_chan = ~ch; frame_data = ~d;
      end
      tick();
      start_seen = 1'b0; frame_done = 1'b0;
    end
    check("R5 still no write before minimum", wr_valid, 0);
    tick();
    check("R5 write raised at minimum", wr_valid, 1);
    check("R5 write channel", wr_chan, ch);
    check(intrude ? "R8 data unaffected by ignored frame" : "R5 write data", wr_data, d);
    prog_req = 1'b0;
    for (int i = 0; i < stall; i++) begin
      tick();
      check("R7 valid held while stalled", wr_valid, 1);
      check("R7 data held while stalled", wr_data, d);
    end
    wr_ready = 1'b1; tick(); wr_ready = 1'b0;
    check("R7 valid low after handshake", wr_valid, 0);
    check("R7 busy low after handshake", busy, 0);
    check("R5 one write issued", n_wr - wr0, 1);
    check("R5 written data", last_data, d);
    check("R5 written channel", last_chan, ch);
    tick();
  endtask

  task automatic expect_discard(input string tag, input int wr0);
    check({tag, " not busy"}, busy, 0);
    check({tag, " no discard yet"}, discard, 0);
    tick();
    check({tag, " discard pulse"}, discard, 1);
    tick();
    check({tag, " discard one cycle"}, discard, 0);
    check({tag, " no write"}, n_wr - wr0, 0);
    prog_req = 1'b0;
    tick();
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int wr0;
    tick(); tick();
    check("R1 busy in reset", busy, 0);
    check("R1 wr_valid in reset", wr_valid, 0);
    check("R1 discard in reset", discard, 0);
    rst_n = 1'b1; cs = 1'b1; tick();

    // Accepted commits across channels, data patterns and stall lengths.
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'((ch * 37 + 1) & 255);
        commit(2'(ch), d, (ch + k) % 3, 1'b0);
      end
    end

    // R10: same value committed twice gives two writes.
    wr0 = n_wr;
    commit(2'd2, 8'h3C, 0, 1'b0);
    commit(2'd2, 8'h3C, 1, 1'b0);
    check("R10 two writes for same value", n_wr - wr0, 2);

    // R8: frame pulses during programming are ignored.
    commit(2'd1, 8'hA5, 1, 1'b1);

    // R4: request absent at the qualification edge (rising later).
    for (int ch = 0; ch < 4; ch++) begin
      wr0 = n_wr;
      frame(2'(ch), 8'(ch * 17), 1'b0, 1'b0);
      prog_req = 1'b1;
      expect_discard("R4", wr0);
    end

    // R3: request already high when the start bit is taken.
    for (int ch = 0; ch < 4; ch++) begin
      wr0 = n_wr;
      frame(2'(ch), 8'(ch * 29 + 3), 1'b1, 1'b1);
      expect_discard("R3", wr0);
    end

    // R6: request dropped at every point before the minimum.
    for (int k = 0; k < MINC; k++) begin
      wr0 = n_wr;
      frame(2'd3, 8'(k + 8'h40), 1'b0, 1'b1);
      for (int i = 0; i < k; i++) tick();
      prog_req = 1'b0; tick();
      check("R6 busy low after early drop", busy, 0);
      tick();
      check("R6 no discard after abort", discard, 0);
      tick();
      check("R6 no write after abort", n_wr - wr0, 0);
    end

    // R9: chip select falls on the qualification edge.
    wr0 = n_wr;
    start_seen = 1'b1; tick(); start_seen = 1'b0; tick();
    frame_done = 1'b1; frame_data = 8'h77; tick(); frame_done = 1'b0;
    prog_req = 1'b1; cs = 1'b0; tick();
    check("R9 not busy with cs low", busy, 0);
    tick();
    check("R9 no discard with cs low", discard, 0);
    prog_req = 1'b0; cs = 1'b1; tick();
    check("R9 no write with cs low", n_wr - wr0, 0);

    // R9: chip select falls during programming.
    wr0 = n_wr;
    frame(2'd0, 8'h11, 1'b0, 1'b1);
    tick(); cs = 1'b0; tick();
    check("R9 busy low after cs drop in programming", busy, 0);
    for (int i = 0; i < MINC + 2; i++) tick();
    check("R9 no write after cs drop", n_wr - wr0, 0);
    check("R9 no discard after cs drop", discard, 0);
    cs = 1'b1; prog_req = 1'b0; tick();

    // R11: end of frame with no start bit.
    wr0 = n_wr;
    frame_done = 1'b1; frame_data = 8'h99; tick(); frame_done = 1'b0;
    prog_req = 1'b1; tick();
    check("R11 not busy without start", busy, 0);
    tick();
    check("R11 no discard without start", discard, 0);
    tick();
    check("R11 no write without start", n_wr - wr0, 0);
    prog_req = 1'b0; tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule